// File: doc/BRIEF.md
# Line Excessive-Zero Run Counter

This block watches the received bit stream of a serial line and counts runs of consecutive zeros that are long enough to be excessive. Each received bit comes with a one-cycle valid strobe. The length a run needs before it counts depends on the line code. With the zero-substitution mode on, 8 zeros are enough. With the mode off, 16 zeros are needed. A run adds one to the count, however long it grows. After a run has counted, only a received one can start a new run.

The count is 8 bits wide. The host reads it through a 16-bit status word whose upper byte is always zero. The host can overwrite the count through a simple write strobe with data. The count stops at its maximum value and does not wrap to zero.

Top module: `line_zero_run_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the count to 0. The count is visible in `status_word[7:0]`.
- R2: With `subst_mode`=1, the count rises by one on the edge where the 8th consecutive valid zero is taken.
- R3: With `subst_mode`=0, a run of 15 valid zeros adds nothing. The count rises by one on the edge that takes the 16th consecutive valid zero.
- R4: A zero run adds exactly one to the count, however long it lasts. This holds even past 16 zeros.
- R5: A valid one ends the current run. Zeros on both sides of a one are never summed, and the next qualifying run adds one again.
- R6: While `bit_vld` is low, `bit_in` is ignored. The count does not change and the run length does not advance.
- R7: The count saturates at 255. A qualifying run at 255 leaves it at 255.
- R8: A write (`wr_en` high) loads `wr_data` into the count at that edge. If a run qualifies in the same cycle, the written value wins.
- R9: `status_word[15:8]` always reads zero.
- R10: After reset, the run tracker behaves as if a one had just been received. A run of the threshold length that starts right after reset is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe marking `bit_in` as a received bit in this cycle |
| bit_in | input | 1 | Received line bit |
| subst_mode | input | 1 | 1: zero-substitution coding (8-zero threshold); 0: plain coding (16-zero threshold) |
| wr_en | input | 1 | Host write strobe for the count |
| wr_data | input | 8 | Value loaded on a host write |
| status_word | output | 16 | Count in bits 7:0; bits 15:8 are zero |

## Verification
A wrong run-length state shows up at the port as a count step at the wrong bit. The step can come one zero early or late, or twice within one long run. It can also be missing after zeros that were split by a one. Each of these faults is visible on the edge that takes the deciding zero, and the checks sample one half cycle later. A wrong count state shows up as a wrap from 255 to 0, or as a lost or overridden host write. Both are visible on the next status read.

// File: rtl/zrun_pkg.sv
package zrun_pkg;

    // Line-code selection as driven on subst_mode
    typedef enum logic {
        CODE_PLAIN = 1'b0,
        CODE_SUBST = 1'b1
    } line_code_e;

    localparam int DEF_SHORT_THR = 8;
    localparam int DEF_LONG_THR  = 16;
    localparam int DEF_CNT_W     = 8;
    localparam int DEF_WORD_W    = 16;

endpackage

// File: rtl/zrun_len_tracker.sv
module zrun_len_tracker
    import zrun_pkg::*;
#(
    parameter int SHORT_THR = DEF_SHORT_THR,
    parameter int LONG_THR  = DEF_LONG_THR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  line_code_e code_sel,
    output logic       run_hit
);
    localparam int RUN_MAX = (LONG_THR > SHORT_THR) ? LONG_THR : SHORT_THR;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] SHORT_LAST = RUN_W'(SHORT_THR - 1);
    localparam logic [RUN_W-1:0] LONG_LAST  = RUN_W'(LONG_THR - 1);
    localparam logic [RUN_W-1:0] RUN_CAP    = RUN_W'(RUN_MAX);

    typedef struct packed {
        logic [RUN_W-1:0] len;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [RUN_W-1:0] last_before_hit;
    logic             hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        last_before_hit = (code_sel == CODE_SUBST) ? SHORT_LAST : LONG_LAST;
        if (bit_vld) begin
            if (bit_in) begin
                st_d.len = '0;
            end else begin
                // the run reaches the threshold on this zero
                hit_d = (st_q.len == last_before_hit);
                if (st_q.len != RUN_CAP) begin
                    st_d.len = st_q.len + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.len <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_hit = hit_d;

endmodule

// File: rtl/zrun_event_counter.sv
module zrun_event_counter
    import zrun_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val = wr_data;
        end else if (inc && (st_q.val != CNT_TOP)) begin
            st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.val;

endmodule

// File: rtl/line_zero_run_counter.sv
module line_zero_run_counter
    import zrun_pkg::*;
#(
    parameter int SHORT_THR = DEF_SHORT_THR,
    parameter int LONG_THR  = DEF_LONG_THR,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int WORD_W    = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              subst_mode,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [WORD_W-1:0] status_word
);
    localparam int PAD_W = WORD_W - CNT_W;

    logic             run_hit;
    logic [CNT_W-1:0] cnt;
    line_code_e       code_sel;

    assign code_sel = line_code_e'(subst_mode);

    zrun_len_tracker #(
        .SHORT_THR(SHORT_THR),
        .LONG_THR (LONG_THR)
    ) trk_i (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .code_sel(code_sel),
        .run_hit (run_hit)
    );

    zrun_event_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .inc    (run_hit),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .cnt    (cnt)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_word = {{PAD_W{1'b0}}, cnt};
        end else begin : g_nopad
            assign status_word = cnt[WORD_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/line_zero_run_counter_chk.sv
module line_zero_run_counter_chk #(
    parameter int CNT_W  = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_vld,
    input logic              bit_in,
    input logic              wr_en,
    input logic [CNT_W-1:0]  wr_data,
    input logic [WORD_W-1:0] status_word
);
    logic [CNT_W-1:0] c;
    assign c = status_word[CNT_W-1:0];

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (c == '0));

    assert_step_once_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |->
            ((c == $past(c)) || (c == $past(c) + 1'b1)));

    assert_one_no_count_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $past(bit_vld) && $past(bit_in)) |-> $stable(c));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && !$past(bit_vld)) |-> $stable(c));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && ($past(c) == {CNT_W{1'b1}})) |-> (c == {CNT_W{1'b1}}));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> (c == $past(wr_data)));

    generate
        if (WORD_W > CNT_W) begin : g_upper
            assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
                status_word[WORD_W-1:CNT_W] == '0);
        end
    endgenerate

endmodule

bind line_zero_run_counter line_zero_run_counter_chk #(
    .CNT_W (CNT_W),
    .WORD_W(WORD_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .status_word(status_word)
);

// File: tb/line_zero_run_counter_tb_top.sv
`timescale 1ns/1ps
module line_zero_run_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        subst_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] status_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_zero_run_counter dut_i (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .subst_mode (subst_mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .status_word(status_word)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count and upper byte checked together
    task automatic check_cnt(input string req, input int exp);
        check(req, int'(status_word[7:0]), exp);
        check("R9", int'(status_word[15:8]), 0);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_cnt("R1", 0);
    endtask

    task automatic t_subst_mode();
        subst_mode = 1'b1;
        do_reset();
        send_zeros(7);
        check_cnt("R10", 0);
        send_zeros(1);
        check_cnt("R2", 1);
        send_zeros(30);
        check_cnt("R4", 1);
        send_bit(1'b1);
        send_zeros(8);
        check_cnt("R5", 2);
    endtask

    task automatic t_plain_mode();
        subst_mode = 1'b0;
        host_write(8'd0);
        send_bit(1'b1);
        send_zeros(15);
        check_cnt("R3", 0);
        send_zeros(1);
        check_cnt("R3", 1);
        send_zeros(40);
        check_cnt("R4", 1);
        send_bit(1'b1);
        send_zeros(16);
        check_cnt("R3", 2);
        subst_mode = 1'b1;
    endtask

    task automatic t_split_runs();
        host_write(8'd10);
        send_bit(1'b1);
        send_zeros(7);
        send_bit(1'b1);
        send_zeros(7);
        check_cnt("R5", 10);
        send_bit(1'b1);
    endtask

    task automatic t_valid_gate();
        host_write(8'd20);
        send_bit(1'b1);
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        repeat (20) @(negedge clk);
        check_cnt("R6", 20);
        send_zeros(7);
        check_cnt("R6", 20);
        send_zeros(1);
        check_cnt("R6", 21);
    endtask

    task automatic t_saturate();
        host_write(8'd254);
        send_bit(1'b1);
        send_zeros(8);
        check_cnt("R7", 255);
        send_bit(1'b1);
        send_zeros(8);
        check_cnt("R7", 255);
    endtask

    task automatic t_write();
        host_write(8'd100);
        check_cnt("R8", 100);
        send_bit(1'b1);
        send_zeros(7);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = 1'b0;
        wr_en   = 1'b1;
        wr_data = 8'd50;
        @(negedge clk);
        bit_vld = 1'b0;
        wr_en   = 1'b0;
        check_cnt("R8", 50);
        send_zeros(5);
        check_cnt("R8", 50);
    endtask

    task automatic t_reset_mid_run();
        send_bit(1'b1);
        send_zeros(5);
        do_reset();
        send_zeros(7);
        check_cnt("R10", 0);
        send_zeros(1);
        check_cnt("R10", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_subst_mode();
        t_plain_mode();
        t_split_runs();
        t_valid_gate();
        t_saturate();
        t_write();
        t_reset_mid_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule